// File: doc/BRIEF.md
# Carry-Save Unsigned Multiplier-Adder

This block is a purely combinational unsigned multiply-accumulate primitive. It multiplies an `XW`-bit operand by a `YW`-bit operand and adds four extra addend inputs in the same pass. The result is `XW+YW+1` bits wide. All addends at their maximum, together with the largest operands, give a result of all ones. The result therefore never wraps.

The logic has three stages. An AND plane forms every partial product. A grid of full-adder cells then reduces the partial products and the addends in carry-save form: each cell passes its sum to the cell below and its carry diagonally to the next row, so no carry ripples inside a row. A short ripple-carry adder then merges the last row of sums with the last row of carries.

The free inputs of the grid become addend ports:
- two `YW`-bit vectors enter the first row;
- an `XW`-bit vector enters along the most significant column, with bit `k` at weight `2^(YW+k)`;
- one single bit is the carry-in of the final adder, at weight `2^XW`.

No state, clock or reset exists. The block has no modes; the only variants are the two width parameters. Both widths must be at least 2.

Top module: `csa_muladd`

## Requirements
- R1: For every input combination, `prod` equals `op_x*op_y + top_a + top_b + (side_w << YW) + (fin_c << XW)`. It has no truncation.
- R2: With every input bit set to 1, all `XW+YW+1` bits of `prod` are 1. This is the largest reachable value, and it does not overflow.
- R3: With `top_a`, `top_b`, `side_w` and `fin_c` all zero, `prod` equals `op_x*op_y` and its most significant bit is 0.
- R4: With `op_x` zero, `prod` equals the addend sum alone: `top_a + top_b + (side_w << YW) + (fin_c << XW)`. This holds whatever `op_y` is.
- R5: `top_a` and `top_b` have equal weight. Swapping their values leaves `prod` unchanged.
- R6: `fin_c` alone set to 1, with everything else zero, gives `prod = 2^XW`.
- R7: `side_w` alone, with everything else zero, gives `prod = side_w << YW`.
- R8: The relation of R1 holds for widths other than the default. For example, with `XW=6` and `YW=5` the result is 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | XW | Multiplicand, unsigned; one grid row per bit |
| op_y | input | YW | Multiplier, unsigned; one grid column per bit |
| top_a | input | YW | First-row north addend, bit j at weight 2^j |
| top_b | input | YW | First-row diagonal-carry addend, bit j at weight 2^j |
| side_w | input | XW | Most-significant-column addend, bit k at weight 2^(YW+k) |
| fin_c | input | 1 | Final-adder carry-in, weight 2^XW |
| prod | output | XW+YW+1 | Unsigned result |

## Verification
The block has no stored state, so a wrong internal wire cannot hide: it shows in `prod` for any vector that makes that wire matter, in the same evaluation. A miswired diagonal carry or sum link shows as an error of one weight in a middle or upper result bit. A fault in the ripple stage shows only when a carry must travel across the top bits, as with all-ones inputs. The exhaustive sweep of the 3x3 configuration drives every cell input to both values in every context. A reduced sweep over a wider configuration confirms that the generate structure scales correctly.

// File: rtl/csm_pkg.sv
package csm_pkg;

    // Result width that holds the product plus every addend without wrap.
    function automatic int res_width(input int xw, input int yw);
        return xw + yw + 1;
    endfunction

    // Smallest legal operand width for the reduction grid.
    localparam int MIN_W = 2;

endpackage

// File: rtl/csm_fa.sv
module csm_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    logic hx;

    always_comb begin
        hx = a ^ b;
        s  = hx ^ ci;
        co = (a & b) | (hx & ci);
    end

endmodule

// File: rtl/csm_pp_plane.sv
module csm_pp_plane #(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0]          op_x,
    input  logic [YW-1:0]          op_y,
    output logic [XW-1:0][YW-1:0]  pp
);

    for (genvar gi = 0; gi < XW; gi++) begin : g_row
        for (genvar gj = 0; gj < YW; gj++) begin : g_col
            assign pp[gi][gj] = op_x[gi] & op_y[gj];
        end
    end

    // A zero multiplicand must leave the whole plane empty.
    always_comb begin
        if (op_x == '0) begin
            AST_PP_ZERO: assert (pp == '0) else $error("partial products not empty for zero multiplicand"); // R4
        end
    end

endmodule

// File: rtl/csm_reduce.sv
module csm_reduce #(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0][YW-1:0]  pp,
    input  logic [YW-1:0]          top_a,
    input  logic [YW-1:0]          top_b,
    input  logic [XW-1:0]          side_w,
    output logic [XW-1:0]          low_bits,
    output logic [YW-1:0]          sum_row,
    output logic [YW-1:0]          car_row
);

    import csm_pkg::*;
    localparam int RW = res_width(XW, YW);

    logic [XW-1:0][YW-1:0] s_q;
    logic [XW-1:0][YW-1:0] c_q;
    logic [XW-1:0][YW-1:0] north_in;
    logic [XW-1:0][YW-1:0] diag_in;

    for (genvar gi = 0; gi < XW; gi++) begin : g_row
        for (genvar gj = 0; gj < YW; gj++) begin : g_col
            if (gi == 0) begin : g_first
                assign north_in[gi][gj] = top_a[gj];
                assign diag_in[gi][gj]  = top_b[gj];
            end else begin : g_inner
                if (gj == YW - 1) begin : g_edge
                    assign north_in[gi][gj] = side_w[gi-1];
                end else begin : g_mid
                    assign north_in[gi][gj] = s_q[gi-1][gj+1];
                end
                assign diag_in[gi][gj] = c_q[gi-1][gj];
            end
            csm_fa u_cell (
                .a  (pp[gi][gj]),
                .b  (north_in[gi][gj]),
                .ci (diag_in[gi][gj]),
                .s  (s_q[gi][gj]),
                .co (c_q[gi][gj])
            );
        end
        assign low_bits[gi] = s_q[gi][0];
    end

    assign sum_row = {side_w[XW-1], s_q[XW-1][YW-1:1]};
    assign car_row = c_q[XW-1];

    // Carry-save form must conserve the weighted total of all inputs.
    always_comb begin : chk_conserve
        logic [RW-1:0] lhs;
        logic [RW-1:0] rhs;
        rhs = RW'(top_a) + RW'(top_b) + (RW'(side_w) << YW);
        for (int i = 0; i < XW; i++) begin
            for (int j = 0; j < YW; j++) begin
                rhs = rhs + (RW'(pp[i][j]) << (i + j));
            end
        end
        lhs = RW'(low_bits) + (RW'(sum_row) << XW) + (RW'(car_row) << XW);
        AST_CS_CONSERVE: assert (lhs == rhs) else $error("carry-save rows lost weight"); // R1
    end

endmodule

// File: rtl/csm_final_add.sv
module csm_final_add #(
    parameter int YW = 3
) (
    input  logic [YW-1:0] op_s,
    input  logic [YW-1:0] op_c,
    input  logic          cin,
    output logic [YW-1:0] sum,
    output logic          cout
);

    logic [YW:0] cy;

    assign cy[0] = cin;

    for (genvar gk = 0; gk < YW; gk++) begin : g_bit
        csm_fa u_fa (
            .a  (op_s[gk]),
            .b  (op_c[gk]),
            .ci (cy[gk]),
            .s  (sum[gk]),
            .co (cy[gk+1])
        );
    end

    assign cout = cy[YW];

    // Ripple result must equal the exact sum with its carry out kept.
    always_comb begin
        AST_NO_OVERFLOW: assert ({cout, sum} == ((YW+1)'(op_s) + (YW+1)'(op_c) + (YW+1)'(cin)))
            else $error("final adder result not exact"); // R2
    end

endmodule

// File: rtl/csa_muladd.sv
module csa_muladd #(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0]        op_x,
    input  logic [YW-1:0]        op_y,
    input  logic [YW-1:0]        top_a,
    input  logic [YW-1:0]        top_b,
    input  logic [XW-1:0]        side_w,
    input  logic                 fin_c,
    output logic [XW+YW:0]       prod
);

    import csm_pkg::*;
    localparam int RW = res_width(XW, YW);

    logic [XW-1:0][YW-1:0] pp;
    logic [XW-1:0]         low_bits;
    logic [YW-1:0]         sum_row;
    logic [YW-1:0]         car_row;
    logic [YW-1:0]         hi_sum;
    logic                  hi_cout;

    csm_pp_plane #(.XW(XW), .YW(YW)) u_plane (
        .op_x (op_x),
        .op_y (op_y),
        .pp   (pp)
    );

    csm_reduce #(.XW(XW), .YW(YW)) u_reduce (
        .pp       (pp),
        .top_a    (top_a),
        .top_b    (top_b),
        .side_w   (side_w),
        .low_bits (low_bits),
        .sum_row  (sum_row),
        .car_row  (car_row)
    );

    csm_final_add #(.YW(YW)) u_final (
        .op_s (sum_row),
        .op_c (car_row),
        .cin  (fin_c),
        .sum  (hi_sum),
        .cout (hi_cout)
    );

    assign prod = {hi_cout, hi_sum, low_bits};

    always_comb begin
        if (XW < MIN_W || YW < MIN_W) begin
            AST_WIDTH_OK: assert (0) else $error("operand widths below minimum"); // R8
        end
        if (top_a == '0 && top_b == '0 && side_w == '0 && !fin_c) begin
            AST_MULT_ONLY: assert (prod == (RW'(op_x) * RW'(op_y)) && !prod[RW-1])
                else $error("pure product wrong"); // R3
        end
        if (&{op_x, op_y, top_a, top_b, side_w, fin_c}) begin
            AST_ALL_ONES: assert (&prod) else $error("maximum inputs did not give all ones"); // R2
        end
    end

endmodule

// File: tb/test_csa_muladd.sv
module test_csa_muladd;

    localparam int CLK_PERIOD = 10;
    localparam int AX = 3;
    localparam int AY = 3;
    localparam int BX = 6;
    localparam int BY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [AX-1:0]    x0;
    logic [AY-1:0]    y0, a0, b0;
    logic [AX-1:0]    w0;
    logic             f0;
    logic [AX+AY:0]   p0;

    logic [BX-1:0]    x1;
    logic [BY-1:0]    y1, a1, b1;
    logic [BX-1:0]    w1;
    logic             f1;
    logic [BX+BY:0]   p1;

    csa_muladd #(.XW(AX), .YW(AY)) i_csa_muladd (
        .op_x(x0), .op_y(y0), .top_a(a0), .top_b(b0),
        .side_w(w0), .fin_c(f0), .prod(p0)
    );

    csa_muladd #(.XW(BX), .YW(BY)) i_csa_muladd_wide (
        .op_x(x1), .op_y(y1), .top_a(a1), .top_b(b1),
        .side_w(w1), .fin_c(f1), .prod(p1)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ref0(input int x, input int y, input int a,
                                    input int b, input int w, input int f);
        return longint'(x) * y + a + b + (longint'(w) << AY) + (longint'(f) << AX);
    endfunction

    task automatic drive0(input int x, input int y, input int a,
                          input int b, input int w, input int f);
        @(posedge clk);
        x0 = AX'(x); y0 = AY'(y); a0 = AY'(a); b0 = AY'(b); w0 = AX'(w); f0 = f[0];
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint held;
        x0 = '0; y0 = '0; a0 = '0; b0 = '0; w0 = '0; f0 = 1'b0;
        x1 = '0; y1 = '0; a1 = '0; b1 = '0; w1 = '0; f1 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle zero", longint'(p0), 0);

        // R2: maximum everywhere
        drive0(7, 7, 7, 7, 7, 1);
        check("R2 all ones", longint'(p0), 127);

        // R3: pure multiply
        drive0(7, 7, 0, 0, 0, 0);
        check("R3 7x7", longint'(p0), 49);
        drive0(5, 6, 0, 0, 0, 0);
        check("R3 5x6", longint'(p0), 30);

        // R4: zero multiplicand
        drive0(0, 7, 3, 5, 6, 1);
        check("R4 x zero", longint'(p0), 3 + 5 + (6 << AY) + (1 << AX));

        // R5: addend symmetry
        drive0(3, 5, 6, 1, 2, 0);
        held = longint'(p0);
        drive0(3, 5, 1, 6, 2, 0);
        check("R5 swap", longint'(p0), held);
        check("R5 value", longint'(p0), ref0(3, 5, 1, 6, 2, 0));

        // R6: final carry-in weight
        drive0(0, 0, 0, 0, 0, 1);
        check("R6 carry-in", longint'(p0), 8);

        // R7: side addend weight
        drive0(0, 0, 0, 0, 5, 0);
        check("R7 side addend", longint'(p0), 5 << AY);
        drive0(0, 0, 0, 0, 7, 0);
        check("R7 side max", longint'(p0), 7 << AY);

        // R1: exhaustive sweep of the 3x3 configuration
        for (int v = 0; v < 65536; v++) begin
            int vx, vy, va, vb, vw, vf;
            vx = v & 7;
            vy = (v >> 3) & 7;
            va = (v >> 6) & 7;
            vb = (v >> 9) & 7;
            vw = (v >> 12) & 7;
            vf = (v >> 15) & 1;
            drive0(vx, vy, va, vb, vw, vf);
            check("R1 sweep", longint'(p0), ref0(vx, vy, va, vb, vw, vf));
        end

        // R8: wider configuration, random vectors plus the maximum
        for (int k = 0; k < 2000; k++) begin
            longint e;
            @(posedge clk);
            if (k == 0) begin
                x1 = '1; y1 = '1; a1 = '1; b1 = '1; w1 = '1; f1 = 1'b1;
            end else begin
                x1 = BX'($urandom); y1 = BY'($urandom); a1 = BY'($urandom);
                b1 = BY'($urandom); w1 = BX'($urandom); f1 = 1'($urandom);
            end
            @(negedge clk);
            e = longint'(x1) * longint'(y1) + longint'(a1) + longint'(b1)
                + (longint'(w1) << BY) + (longint'(f1) << BX);
            check("R8 wide", longint'(p1), e);
        end
        finish_run();
    end

endmodule